// File: doc/BRIEF.md
# Character-Display Sync Pulse Generator

This block produces the horizontal and vertical sync pulses for a character-based display timing controller. A character counter runs across each scanline, a scanline counter runs within each character row, and a row counter runs across the frame. Horizontal sync starts at a programmed character position, and vertical sync starts at a programmed row. The width of each pulse comes from one packed sync-width input.

A two-bit personality input picks one of four controller variants. The variants read the width fields differently. In the horizontal direction, a variant either checks the count before stepping it or steps it first and then checks. This decides what a width of zero means. In the vertical direction, a variant either honours the programmed line count or always gives a fixed sixteen-line pulse. The enclosing controller supplies the totals and positions as static configuration and uses `hsync` and `vsync` directly as its sync pins.

Top module: `crtc_sync_gen`

## Requirements
- R1: While `rst` is sampled high at a clock edge, both `hsync` and `vsync` are low after that edge. All internal counters restart from zero.
- R2: The character count steps from 0 to `h_total` and then wraps to 0. `hsync` goes high in the clock cycle that follows the edge at which the character count equals `h_sync_pos`.
- R3: For personality 0 (2'b00) and personality 1 (2'b01), a horizontal width W in `sync_width[3:0]` from 1 to 15 keeps `hsync` high for exactly W character clocks.
- R4: For personality 0 and personality 1, a horizontal width of zero produces no `hsync` pulse at all.
- R5: For personality 2 (2'b10) and personality 3 (2'b11), `hsync` lasts W character clocks for W from 1 to 15. A width of zero gives a 16-character pulse.
- R6: The scanline count wraps after `scan_max` and the row count wraps after `v_total`. `vsync` goes high on the first character of scanline 0 of row `v_sync_pos`, and it changes only at scanline boundaries.
- R7: For personality 0 and personality 3, `vsync` lasts V scanlines, where V is `sync_width[7:4]`. A value of zero gives 16 scanlines.
- R8: For personality 1 and personality 2, `sync_width[7:4]` has no effect, and `vsync` always lasts exactly 16 scanlines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| personality | input | 2 | Variant select, 0 to 3 |
| h_total | input | CHAR_W | Last character index of a scanline |
| h_sync_pos | input | CHAR_W | Character index at which hsync starts |
| v_total | input | ROW_W | Last row index of a frame |
| scan_max | input | SCAN_W | Last scanline index within a row |
| v_sync_pos | input | ROW_W | Row at which vsync starts |
| sync_width | input | 2*SW_BITS | [3:0] horizontal width, [7:4] vertical width |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |

## Verification
The assertions take several things for granted about the inputs. Personality and widths stay fixed while a pulse is running. A scanline holds at least sixteen characters, so `hsync` cannot restart before it has ended. A frame holds more than sixteen scanlines, and both sync positions lie within their totals. The bench keeps to these conditions. It fixes a 20-character line, 2-line rows and a 12-row frame, and it changes personality and width only while reset is held. Every personality is run against several width patterns, including zero and fifteen in each field.

// File: rtl/crtc_sync_pkg.sv
package crtc_sync_pkg;

   typedef enum logic [1:0] {
      VARIANT_A = 2'd0,
      VARIANT_B = 2'd1,
      VARIANT_C = 2'd2,
      VARIANT_D = 2'd3
   } variant_e;

   // Horizontal counter is stepped before the width compare (variants C and D)
   function automatic logic hs_step_first(input logic [1:0] sel);
      return sel[1];
   endfunction

   // Vertical width field is honoured (variants A and D)
   function automatic logic vs_width_used(input logic [1:0] sel);
      return (sel == VARIANT_A) || (sel == VARIANT_D);
   endfunction

endpackage

// File: rtl/crtc_timebase.sv
module crtc_timebase #(
   parameter int CHAR_W = 8,
   parameter int SCAN_W = 5,
   parameter int ROW_W  = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CHAR_W-1:0] h_total,
   input  logic [SCAN_W-1:0] scan_max,
   input  logic [ROW_W-1:0]  v_total,
   output logic [CHAR_W-1:0] char_cnt,
   output logic              line_end,
   output logic              row_turn,
   output logic [ROW_W-1:0]  next_row
);

   logic [SCAN_W-1:0] scan_cnt;
   logic [ROW_W-1:0]  row_cnt;

   assign line_end = (char_cnt >= h_total);
   assign row_turn = line_end && (scan_cnt >= scan_max);
   assign next_row = (row_cnt >= v_total) ? '0 : ROW_W'(row_cnt + 1'b1);

   always_ff @(posedge clk) begin
      if (rst) begin
         char_cnt <= '0;
         scan_cnt <= '0;
         row_cnt  <= '0;
      end else if (line_end) begin
         char_cnt <= '0;
         if (row_turn) begin
            scan_cnt <= '0;
            row_cnt  <= next_row;
         end else begin
            scan_cnt <= SCAN_W'(scan_cnt + 1'b1);
         end
      end else begin
         char_cnt <= CHAR_W'(char_cnt + 1'b1);
      end
   end

   p_char_wrap_r2: assert property (@(posedge clk) disable iff (rst)
      line_end |=> (char_cnt == '0))
      else $error("character count did not wrap after line end");

   p_char_step_r2: assert property (@(posedge clk) disable iff (rst)
      !line_end |=> (char_cnt == CHAR_W'($past(char_cnt) + 1'b1)))
      else $error("character count skipped");

endmodule

// File: rtl/crtc_hsync.sv
module crtc_hsync #(
   parameter int CHAR_W  = 8,
   parameter int SW_BITS = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               step_first,
   input  logic [CHAR_W-1:0]  char_cnt,
   input  logic [CHAR_W-1:0]  h_pos,
   input  logic [SW_BITS-1:0] width,
   output logic               hs
);

   logic [SW_BITS-1:0] cnt;
   logic [SW_BITS-1:0] cnt_next;
   logic               start;

   assign start    = (char_cnt == h_pos);
   assign cnt_next = SW_BITS'(cnt + 1'b1);

   always_ff @(posedge clk) begin
      if (rst) begin
         hs  <= 1'b0;
         cnt <= '0;
      end else if (start) begin
         if (step_first) begin
            hs  <= 1'b1;
            cnt <= '0;
         end else begin
            // compare the cleared count, then step it
            hs  <= (width != '0);
            cnt <= SW_BITS'(1);
         end
      end else if (hs) begin
         cnt <= cnt_next;
         hs  <= step_first ? (cnt_next != width) : (cnt != width);
      end
   end

   p_hs_rise_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(hs) |-> $past(start))
      else $error("hsync rose without a start match");

   p_hs_zero_r4: assert property (@(posedge clk) disable iff (rst)
      (start && !step_first && width == '0) |=> !hs)
      else $error("zero width produced a pulse");

   p_hs_full_r5: assert property (@(posedge clk) disable iff (rst)
      (start && step_first) |=> hs)
      else $error("step-first variant did not start a pulse");

   p_hs_count_r3: assert property (@(posedge clk) disable iff (rst)
      (hs && !step_first) |-> (cnt != '0))
      else $error("compare-first count wrapped during a pulse");

endmodule

// File: rtl/crtc_vsync.sv
module crtc_vsync #(
   parameter int SW_BITS = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               width_used,
   input  logic               line_end,
   input  logic               start,
   input  logic [SW_BITS-1:0] width,
   output logic               vs
);

   logic [SW_BITS-1:0] cnt;
   logic [SW_BITS-1:0] cnt_next;

   assign cnt_next = SW_BITS'(cnt + 1'b1);

   always_ff @(posedge clk) begin
      if (rst) begin
         vs  <= 1'b0;
         cnt <= '0;
      end else if (start) begin
         vs  <= 1'b1;
         cnt <= '0;
      end else if (vs && line_end) begin
         cnt <= cnt_next;
         vs  <= width_used ? (cnt_next != width) : (cnt_next != '0);
      end
   end

   p_vs_rise_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(vs) |-> $past(start))
      else $error("vsync rose outside a frame start point");

   p_vs_line_r6: assert property (@(posedge clk) disable iff (rst)
      (vs && !line_end && !start) |=> vs)
      else $error("vsync ended mid scanline");

   p_vs_fixed_r8: assert property (@(posedge clk) disable iff (rst)
      (!width_used && $fell(vs)) |-> ($past(cnt) == '1))
      else $error("fixed vsync ended before sixteen lines");

endmodule

// File: rtl/crtc_sync_gen.sv
module crtc_sync_gen #(
   parameter int CHAR_W  = 8,
   parameter int SCAN_W  = 5,
   parameter int ROW_W   = 7,
   parameter int SW_BITS = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [1:0]           personality,
   input  logic [CHAR_W-1:0]    h_total,
   input  logic [CHAR_W-1:0]    h_sync_pos,
   input  logic [ROW_W-1:0]     v_total,
   input  logic [SCAN_W-1:0]    scan_max,
   input  logic [ROW_W-1:0]     v_sync_pos,
   input  logic [2*SW_BITS-1:0] sync_width,
   output logic                 hsync,
   output logic                 vsync
);
   import crtc_sync_pkg::*;

   localparam int WREG_W = 2 * SW_BITS;

   generate
      if (SW_BITS < 2) begin : g_bad_sw
         $error("SW_BITS must be at least 2");
      end
      if (CHAR_W < SW_BITS || SCAN_W < 1 || ROW_W < 1) begin : g_bad_dims
         $error("counter widths too small for the sync counters");
      end
   endgenerate

   logic [CHAR_W-1:0]  char_cnt;
   logic               line_end;
   logic               row_turn;
   logic [ROW_W-1:0]   next_row;
   logic [SW_BITS-1:0] h_width;
   logic [SW_BITS-1:0] v_width;
   logic               v_start;

   assign h_width = sync_width[SW_BITS-1:0];
   assign v_width = sync_width[WREG_W-1:SW_BITS];
   assign v_start = row_turn && (next_row == v_sync_pos);

   crtc_timebase #(.CHAR_W(CHAR_W), .SCAN_W(SCAN_W), .ROW_W(ROW_W)) u_timebase (
      .clk      (clk),
      .rst      (rst),
      .h_total  (h_total),
      .scan_max (scan_max),
      .v_total  (v_total),
      .char_cnt (char_cnt),
      .line_end (line_end),
      .row_turn (row_turn),
      .next_row (next_row)
   );

   crtc_hsync #(.CHAR_W(CHAR_W), .SW_BITS(SW_BITS)) u_hsync (
      .clk        (clk),
      .rst        (rst),
      .step_first (hs_step_first(personality)),
      .char_cnt   (char_cnt),
      .h_pos      (h_sync_pos),
      .width      (h_width),
      .hs         (hsync)
   );

   crtc_vsync #(.SW_BITS(SW_BITS)) u_vsync (
      .clk        (clk),
      .rst        (rst),
      .width_used (vs_width_used(personality)),
      .line_end   (line_end),
      .start      (v_start),
      .width      (v_width),
      .vs         (vsync)
   );

   p_reset_r1: assert property (@(posedge clk)
      rst |=> (!hsync && !vsync))
      else $error("sync outputs not cleared by reset");

endmodule

// File: tb/test_crtc_sync_gen.sv
module test_crtc_sync_gen;

   localparam int HT = 19;
   localparam int HP = 3;
   localparam int SM = 1;
   localparam int VT = 11;
   localparam int VP = 5;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] personality = 2'd0;
   logic [7:0] sync_width = 8'h00;
   logic       hsync;
   logic       vsync;

   always #10 clk = ~clk;

   crtc_sync_gen i_crtc_sync_gen (
      .clk         (clk),
      .rst         (rst),
      .personality (personality),
      .h_total     (8'(HT)),
      .h_sync_pos  (8'(HP)),
      .v_total     (7'(VT)),
      .scan_max    (5'(SM)),
      .v_sync_pos  (7'(VP)),
      .sync_width  (sync_width),
      .hsync       (hsync),
      .vsync       (vsync)
   );

   typedef struct {
      logic  h;
      logic  v;
      string th;
      string tv;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   failures = 0;
   bit   done = 1'b0;

   // expected-value producer: timing derived from R2, R6 and the width rules
   int mc = 0, ms = 0, mr = 0, hrem = 0, vrem = 0;

   function automatic int h_eff(input logic [1:0] p, input logic [3:0] w);
      if (w != 0) return int'(w);
      return (p >= 2) ? 16 : 0;             // R5 versus R4
   endfunction

   function automatic int v_eff(input logic [1:0] p, input logic [3:0] w);
      if (p == 2'd1 || p == 2'd2) return 16; // R8
      return (w == 0) ? 16 : int'(w);        // R7
   endfunction

   always @(posedge clk) begin
      exp_t e;
      if (rst) begin
         mc = 0; ms = 0; mr = 0; hrem = 0; vrem = 0;
         e.h = 1'b0; e.v = 1'b0; e.th = "R1"; e.tv = "R1";
      end else begin
         bit le, rt;
         int nr;
         le = (mc == HT);
         rt = le && (ms == SM);
         nr = (mr == VT) ? 0 : mr + 1;
         if (mc == HP) hrem = h_eff(personality, sync_width[3:0]);
         else if (hrem > 0) hrem--;
         if (rt && nr == VP) vrem = v_eff(personality, sync_width[7:4]);
         else if (le && vrem > 0) vrem--;
         if (le) begin
            mc = 0;
            if (rt) begin ms = 0; mr = nr; end
            else ms++;
         end else begin
            mc++;
         end
         e.h = (hrem > 0);
         e.v = (vrem > 0);
         e.th = (personality >= 2) ? "R2,R5" :
                (sync_width[3:0] == 0) ? "R4" : "R2,R3";
         e.tv = (personality == 2'd1 || personality == 2'd2) ? "R6,R8" : "R6,R7";
      end
      q.push_back(e);
   end

   // monitor: compares away from the active edge
   always @(negedge clk) begin
      if (!done && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (hsync !== e.h) begin
            failures++;
            $display("FAIL %s hsync: actual=%b expected=%b pers=%0d width=%h t=%0t",
                     e.th, hsync, e.h, personality, sync_width, $time);
         end
         checks++;
         if (vsync !== e.v) begin
            failures++;
            $display("FAIL %s vsync: actual=%b expected=%b pers=%0d width=%h t=%0t",
                     e.tv, vsync, e.v, personality, sync_width, $time);
         end
      end
   end

   task automatic run_cfg(input logic [1:0] p, input logic [7:0] w, input int cycles);
      @(negedge clk);
      rst = 1'b1;
      personality = p;
      sync_width = w;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      repeat (cycles) @(negedge clk);
   endtask

   initial begin
      logic [7:0] widths [5];
      widths[0] = 8'h35;   // R3 / R5 / R7 nominal
      widths[1] = 8'h00;   // R4, R5 and R7 zero cases
      widths[2] = 8'hF1;   // width one, vertical fifteen
      widths[3] = 8'h7F;   // horizontal fifteen
      widths[4] = 8'h1A;   // R8: vertical field of one ignored on 1 and 2
      repeat (3) @(negedge clk);   // R1 reset state held
      for (int p = 0; p < 4; p++) begin
         for (int k = 0; k < 5; k++) begin
            run_cfg(2'(p), widths[k], 700);
         end
      end
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule